// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block fronts a byte-wide static RAM that is paired with a nonvolatile shadow array of the same depth. Four active-low strobes (chip select, output enable, write enable and a nonvolatile select) are decoded on every clock. With the nonvolatile select high, the port behaves as a plain synchronous SRAM. With it low, the strobes request a whole-array copy in one of two directions: a recall (shadow into RAM) or a store (RAM into shadow). Both arrays are synchronous simple-dual-port memories that map onto block RAM. The shadow programming time is modelled by a cycle timer that runs after the copy.

Supply sensing arrives as a digital supply-good level. While it is low, nothing runs. When it becomes valid, the block recalls the shadow into the RAM on its own, whatever the strobes hold. Stores are guarded in three ways. A RAM write must have happened since the last whole-array operation. The strobe pattern must stay stable for a minimum number of clocks. A pattern that is held across power-up or across a busy period must be released before it can act again.

Top module: `nvsram_ctrl`

## Requirements
- R1: When the supply-good input is high and the block is powered off, an automatic recall starts at the next clock, whatever the strobes hold. `busy` stays high from reset until the recall has run for 2^AW+1 cycles. After that the RAM holds the shadow contents.
- R2: While the supply-good input is low, `busy` is high and `dq_oe` is low. Writes and strobe requests are ignored, and a recall or store in progress is abandoned.
- R3: A read is the pattern ce_n=0, oe_n=0, we_n=1, ne_n=1 while idle. On the next cycle `dq_oe` is 1 and `rdata` holds the RAM byte at the sampled address.
- R4: A write is the pattern ce_n=0, we_n=0, ne_n=1 while idle. It stores `wdata` at `addr` on that clock edge and arms the store guard.
- R5: `dq_oe` is 0 on the cycle after any sample with oe_n=1, ce_n=1, ne_n=0 or we_n=0.
- R6: The recall pattern is ce_n=0, oe_n=0, we_n=1, ne_n=0. Sampled on QUAL_CYC consecutive idle edges, it starts a recall that keeps `busy` high for 2^AW+1 cycles and copies the whole shadow into the RAM.
- R7: The store pattern is ce_n=0, we_n=0, ne_n=0, oe_n=1. Sampled on QUAL_CYC consecutive idle edges while the guard is armed, it starts a store that keeps `busy` high for 2^AW+1+PROG_CYC cycles and copies the whole RAM into the shadow.
- R8: A qualified store pattern is ignored when the guard is not armed. `busy` stays low and the shadow is left unchanged.
- R9: A recall or store pattern that is present on fewer than QUAL_CYC consecutive edges starts nothing.
- R10: A qualified pattern acts once. It must go away before it can qualify again. The same holds for a pattern present when the block leaves power-off or a busy period.
- R11: While `busy` is high, read, write, recall and store requests are ignored.
- R12: The store guard is cleared when a recall or store completes and when the supply goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good level (1 = supply above threshold) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ne_n | input | 1 | Nonvolatile select, active low |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data, valid while dq_oe is 1 |
| dq_oe | output | 1 | Registered data-bus drive enable |
| busy | output | 1 | High while powered off, recalling or storing |

## Verification
The bench goes after the cases where a store or recall could start when it should not. A store pattern is held straight through power-up. A pattern is held one clock short of qualification. A qualified pattern is kept held long after its operation finishes. A store is requested right after a completed store or recall, and again right after a power cycle. A design with a loose guard or a missing release rule would show an unexpected `busy` pulse, and a later recall would read back overwritten shadow data. Writes issued during a store and supply loss in the middle of a recall are also exercised. A design that let a busy-time write through would return the wrong byte on a later read. A design that failed to restart the copy at power-up would leave stale bytes in the RAM.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RCL,
    ST_STO,
    ST_PROG,
    ST_IDLE
  } seq_st_t;

  typedef enum logic [1:0] {
    NV_NONE,
    NV_RECALL,
    NV_STORE
  } nv_kind_t;

endpackage

// File: rtl/nvsram_mem.sv
module nvsram_mem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first simple dual port, maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvsram_strobe_qual.sv
module nvsram_strobe_qual
  import nvsram_pkg::*;
#(
  parameter int QUAL_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic ne_n,
  output logic rd_req,
  output logic wr_req,
  output logic go_recall,
  output logic go_store
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  nv_kind_t       nv_pat;
  nv_kind_t       kind_q;
  logic [CW-1:0]  cnt_q;
  logic           hold_q;
  logic           go;

  always_comb begin
    rd_req = idle && !ce_n && !oe_n && we_n && ne_n;
    wr_req = idle && !ce_n && !we_n && ne_n;
    nv_pat = NV_NONE;
    if (!ce_n && !ne_n) begin
      if (!oe_n && we_n)      nv_pat = NV_RECALL;
      else if (oe_n && !we_n) nv_pat = NV_STORE;
    end
    go = idle && !hold_q && (nv_pat != NV_NONE) && (nv_pat == kind_q)
         && (cnt_q == CW'(QUAL_CYC - 1));
    go_recall = go && (nv_pat == NV_RECALL);
    go_store  = go && (nv_pat == NV_STORE);
  end

  // pattern must be seen on QUAL_CYC consecutive edges, and released after use
  always_ff @(posedge clk) begin
    if (rst || !idle) begin
      cnt_q  <= '0;
      kind_q <= NV_NONE;
      hold_q <= 1'b1;
    end else if (nv_pat == NV_NONE) begin
      cnt_q  <= '0;
      kind_q <= NV_NONE;
      hold_q <= 1'b0;
    end else if (!hold_q) begin
      if (go) begin
        hold_q <= 1'b1;
        cnt_q  <= '0;
      end else if (nv_pat == kind_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        kind_q <= nv_pat;
        cnt_q  <= CW'(1);
      end
    end
  end
endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int PROG_CYC = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  input  logic          go_recall,
  input  logic          go_store,
  input  logic          user_wr,
  output seq_st_t       st_q,
  output logic          busy,
  output logic          arm_q,
  output logic          rcl_we,
  output logic          sto_we,
  output logic [AW-1:0] rd_idx,
  output logic [AW-1:0] wr_idx
);
  localparam int DEPTH = 1 << AW;
  localparam int TW    = $clog2(PROG_CYC + 1);

  seq_st_t       st_d;
  logic [AW:0]   idx_q;
  logic [TW-1:0] tmr_q;
  logic          copy_last;
  logic          prog_last;

  assign copy_last = (idx_q == (AW+1)'(DEPTH));
  assign prog_last = (tmr_q == TW'(PROG_CYC - 1));
  assign rd_idx    = idx_q[AW-1:0];
  assign wr_idx    = idx_q[AW-1:0] - 1'b1;
  assign rcl_we    = (st_q == ST_RCL) && (idx_q != '0);
  assign sto_we    = (st_q == ST_STO) && (idx_q != '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:  st_d = ST_RCL;
      ST_RCL:  if (copy_last) st_d = ST_IDLE;
      ST_STO:  if (copy_last) st_d = ST_PROG;
      ST_PROG: if (prog_last) st_d = ST_IDLE;
      ST_IDLE: begin
        if (go_recall)              st_d = ST_RCL;
        else if (go_store && arm_q) st_d = ST_STO;
      end
      default: st_d = ST_OFF;
    endcase
    if (!pwr_ok) st_d = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      idx_q <= '0;
      tmr_q <= '0;
      busy  <= 1'b1;
    end else begin
      st_q <= st_d;
      busy <= (st_d != ST_IDLE);
      if (st_d != st_q)
        idx_q <= '0;
      else if (st_q == ST_RCL || st_q == ST_STO)
        idx_q <= idx_q + 1'b1;
      if (st_q != ST_PROG) tmr_q <= '0;
      else                 tmr_q <= tmr_q + 1'b1;
    end
  end

  // store guard
  always_ff @(posedge clk) begin
    if (rst || !pwr_ok)
      arm_q <= 1'b0;
    else if ((st_q == ST_RCL && copy_last) || (st_q == ST_PROG && prog_last))
      arm_q <= 1'b0;
    else if (user_wr)
      arm_q <= 1'b1;
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int QUAL_CYC = 5,
  parameter int PROG_CYC = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          ne_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          dq_oe,
  output logic          busy
);
  seq_st_t       st_q;
  logic          arm_q;
  logic          idle;
  logic          rd_req, wr_req, go_recall, go_store;
  logic          rcl_we, sto_we;
  logic [AW-1:0] rd_idx, wr_idx;
  logic [DW-1:0] ram_q, sh_q;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata;

  assign idle = (st_q == ST_IDLE) && pwr_ok && !rst;

  nvsram_strobe_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .idle      (idle),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .ne_n      (ne_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .go_recall (go_recall),
    .go_store  (go_store)
  );

  nvsram_seq #(.AW(AW), .PROG_CYC(PROG_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pwr_ok    (pwr_ok),
    .go_recall (go_recall),
    .go_store  (go_store),
    .user_wr   (wr_req),
    .st_q      (st_q),
    .busy      (busy),
    .arm_q     (arm_q),
    .rcl_we    (rcl_we),
    .sto_we    (sto_we),
    .rd_idx    (rd_idx),
    .wr_idx    (wr_idx)
  );

  assign ram_we    = wr_req || rcl_we;
  assign ram_waddr = rcl_we ? wr_idx : addr;
  assign ram_wdata = rcl_we ? sh_q : wdata;
  assign ram_raddr = (st_q == ST_STO) ? rd_idx : addr;

  nvsram_mem #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  nvsram_mem #(.AW(AW), .DW(DW)) u_shadow (
    .clk   (clk),
    .we    (sto_we),
    .waddr (wr_idx),
    .wdata (ram_q),
    .raddr (rd_idx),
    .rdata (sh_q)
  );

  assign rdata = ram_q;

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= rd_req;
  end
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk
  import nvsram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int PROG_CYC = 200
) (
  input logic    clk,
  input logic    rst,
  input logic    pwr_ok,
  input logic    ce_n,
  input logic    oe_n,
  input logic    we_n,
  input logic    ne_n,
  input logic    busy,
  input logic    dq_oe,
  input logic    arm_q,
  input seq_st_t st_q
);
  localparam int LIMIT = (1 << AW) + 1 + PROG_CYC;

  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_ok || !busy) run_q <= '0;
    else                         run_q <= run_q + 1;
  end

  p_supply_low_r2: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (busy && !dq_oe));

  p_oe_gate_r5: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!ce_n && !oe_n && we_n && ne_n));

  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dq_oe);

  p_store_armed_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STO && $past(st_q) == ST_IDLE) |-> $past(arm_q));

  p_op_time_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && pwr_ok) |-> (run_q <= 32'(LIMIT)));

  p_guard_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !arm_q);
endmodule

bind nvsram_ctrl nvsram_ctrl_chk #(.AW(AW), .PROG_CYC(PROG_CYC)) u_chk (.*);

// File: tb/sim_nvsram_ctrl.sv
module sim_nvsram_ctrl;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int QUAL  = 5;
  localparam int PROG  = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ne_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic dq_oe, busy;

  always #2 clk = ~clk;

  nvsram_ctrl #(.AW(AW), .DW(DW), .QUAL_CYC(QUAL), .PROG_CYC(PROG)) u0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .ne_n(ne_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dq_oe(dq_oe), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R2";
  bit cmp_on = 0;
  bit done = 0;

  // behavioural reference model
  logic [DW-1:0] ram_m [DEPTH];
  logic [DW-1:0] sh_m  [DEPTH];
  bit ram_k [DEPTH];
  bit sh_k  [DEPTH];
  int mode = 0;   // 0 off, 1 recalling, 2 storing, 3 idle
  int rem = 0, run = 0, kind = 0;
  bit hold = 1, arm = 0;
  bit exp_busy = 1, exp_oe = 0, rd_known = 0;
  logic [DW-1:0] exp_rd = '0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram_k[i] = 0; sh_k[i] = 0; ram_m[i] = '0; sh_m[i] = '0;
    end
  end

  function automatic int nv_kind();
    if (!ce_n && !ne_n && !oe_n && we_n) return 1;
    if (!ce_n && !ne_n && oe_n && !we_n) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst || !pwr_ok) begin
      mode = 0; exp_busy = 1; exp_oe = 0; arm = 0; hold = 1; run = 0; kind = 0;
    end else if (mode == 0) begin
      for (int i = 0; i < DEPTH; i++) begin ram_m[i] = sh_m[i]; ram_k[i] = sh_k[i]; end
      mode = 1; rem = DEPTH + 1; exp_busy = 1; exp_oe = 0; hold = 1; run = 0; kind = 0;
    end else if (mode != 3) begin
      hold = 1; run = 0; kind = 0; exp_oe = 0;
      rem--;
      if (rem == 0) begin mode = 3; exp_busy = 0; arm = 0; end
    end else begin
      int p;
      p = nv_kind();
      exp_oe = !ce_n && !oe_n && we_n && ne_n;
      if (exp_oe) begin exp_rd = ram_m[addr]; rd_known = ram_k[addr]; end
      if (!ce_n && !we_n && ne_n) begin
        ram_m[addr] = wdata; ram_k[addr] = 1; arm = 1;
      end
      if (p == 0) begin
        run = 0; hold = 0; kind = 0;
      end else if (!hold) begin
        if (p == kind && run == QUAL - 1) begin
          hold = 1; run = 0;
          if (p == 1) begin
            for (int i = 0; i < DEPTH; i++) begin ram_m[i] = sh_m[i]; ram_k[i] = sh_k[i]; end
            mode = 1; rem = DEPTH + 1; exp_busy = 1;
          end else if (arm) begin
            for (int i = 0; i < DEPTH; i++) begin sh_m[i] = ram_m[i]; sh_k[i] = ram_k[i]; end
            mode = 2; rem = DEPTH + 1 + PROG; exp_busy = 1;
          end
        end else if (p == kind) begin
          run++;
        end else begin
          kind = p; run = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (busy !== exp_busy) begin
        errors++;
        $display("FAIL %s busy actual=%b expected=%b t=%0t", cur_req, busy, exp_busy, $time);
      end
      checks++;
      if (dq_oe !== exp_oe) begin
        errors++;
        $display("FAIL %s dq_oe actual=%b expected=%b t=%0t", cur_req, dq_oe, exp_oe, $time);
      end
      if (exp_oe && rd_known) begin
        checks++;
        if (rdata !== exp_rd) begin
          errors++;
          $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, exp_rd, $time);
        end
      end
    end
  end

  task automatic strobe(input bit c, input bit o, input bit w, input bit n, input int n_cyc);
    ce_n = c; oe_n = o; we_n = w; ne_n = n;
    repeat (n_cyc) @(negedge clk);
  endtask

  task automatic write_byte(input int a, input int d);
    addr = AW'(a); wdata = DW'(d);
    strobe(0, 1, 0, 1, 1);
  endtask

  task automatic read_all();
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a);
      strobe(0, 0, 1, 1, 1);
    end
    strobe(1, 1, 1, 1, 2);
  endtask

  task automatic idle_wait(input int n_cyc);
    strobe(1, 1, 1, 1, n_cyc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    cmp_on = 1;
    cur_req = "R2";                       // reset state, supply low
    repeat (3) @(negedge clk);
    rst = 0;
    strobe(0, 1, 0, 0, 4);                // store pattern while supply low

    cur_req = "R1";                       // auto recall with store pattern held (R10)
    pwr_ok = 1;
    strobe(0, 1, 0, 0, DEPTH + 8);
    cur_req = "R10";
    strobe(0, 1, 0, 0, 2 * QUAL);
    idle_wait(2);

    cur_req = "R4";
    for (int a = 0; a < DEPTH; a++) write_byte(a, a * 7 + 3);
    idle_wait(1);
    cur_req = "R3";
    read_all();

    cur_req = "R5";
    addr = 2;
    strobe(0, 1, 1, 1, 3);
    strobe(1, 0, 1, 1, 3);
    strobe(0, 0, 0, 1, 1);
    idle_wait(1);
    cur_req = "R9";                       // short recall and store pulses
    strobe(0, 0, 1, 0, QUAL - 1);
    idle_wait(2);
    strobe(0, 1, 0, 0, QUAL - 1);
    idle_wait(2);

    cur_req = "R7";
    strobe(0, 1, 0, 0, QUAL + 3);
    cur_req = "R11";
    for (int k = 0; k < 4; k++) write_byte(0, 8'hEE);
    addr = 1;
    strobe(0, 0, 1, 1, 3);
    idle_wait(DEPTH + PROG + 4);
    cur_req = "R12";                      // guard cleared by completed store
    strobe(0, 1, 0, 0, QUAL + 2);
    idle_wait(3);

    cur_req = "R4";
    for (int a = 0; a < DEPTH; a++) write_byte(a, 8'hA0 ^ a);
    idle_wait(1);
    cur_req = "R3";
    read_all();
    cur_req = "R6";
    strobe(0, 0, 1, 0, QUAL);
    idle_wait(DEPTH + 4);
    read_all();
    cur_req = "R8";                       // unarmed store after recall
    strobe(0, 1, 0, 0, QUAL + 2);
    idle_wait(3);

    cur_req = "R12";                      // supply loss clears the guard
    write_byte(3, 8'h5A);
    idle_wait(1);
    pwr_ok = 0;
    cur_req = "R2";
    for (int k = 0; k < 3; k++) write_byte(4, 8'h11);
    idle_wait(2);
    pwr_ok = 1;
    idle_wait(DEPTH + 5);
    cur_req = "R12";
    strobe(0, 1, 0, 0, QUAL + 2);
    idle_wait(3);
    cur_req = "R8";
    read_all();

    cur_req = "R2";                       // abort a recall mid-way
    strobe(0, 0, 1, 0, QUAL);
    idle_wait(4);
    pwr_ok = 0;
    idle_wait(3);
    pwr_ok = 1;
    idle_wait(DEPTH + 5);
    cur_req = "R1";
    read_all();

    cur_req = "R10";                      // held recall pattern acts once
    strobe(0, 0, 1, 0, 3 * DEPTH);
    idle_wait(2);
    cur_req = "R6";
    strobe(0, 0, 1, 0, QUAL);
    idle_wait(DEPTH + 4);
    cur_req = "R3";
    read_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule